// File: doc/BRIEF.md
# Register Bus Port Splitter with Broadcast Option

This block takes a single memory-mapped register master and spreads it over `N_PORTS` identical slave ports, one for each stream of a multi-stream datapath. The master address is divided into two fields. The upper bits pick a port. The lower `ADR_W` bits give the word offset inside that port's window, and only these are forwarded to the slaves. Window `i` therefore begins at word index `i * 2**ADR_W`. Write and read strobes pass combinationally to the chosen slave. Each slave returns its word one cycle after its read strobe. The block then steers that word back to the master together with a read-valid flag.

A build-time parameter `BCAST` turns on broadcast mode. In this mode only window 0 is live. A write to that window is strobed into every port in the same cycle, so all streams receive the same setting. A read of that window returns data from port 0. The windows of the other ports cannot be read, and their writes have no effect.

The read response path is a two-state tracker. `RT_IDLE` means no response is due. `RT_RESP` means a response is on the master this cycle. The transitions are:
- `RT_IDLE` → `RT_RESP` on a read strobe.
- `RT_RESP` → `RT_RESP` on a back-to-back read strobe.
- `RT_RESP` → `RT_IDLE` when no read is issued.

When a read is accepted, the tracker stores the port index and a hit flag. The returned word is taken from the port that was addressed when the read was issued.

Top module: `mm_port_split`

## Requirements
- R1: Master address bits `[ADR_W+SEL_W-1:ADR_W]` form the port index and bits `[ADR_W-1:0]` the offset. Every port's `s_addr` slice carries that offset, and every `s_wdata` slice carries `m_wdata`.
- R2: With `BCAST=0`, a write with an in-range index raises `s_wr` only for the port whose number equals the index, in the same cycle.
- R3: With `BCAST=0`, a read with an in-range index raises `s_rd` only for the indexed port. One cycle later, `m_rdata` shows that port's word at the offset.
- R4: For reads on consecutive cycles to different ports, each response carries the data of the port addressed by its own read.
- R5: An index of `N_PORTS` or more raises no `s_wr` and no `s_rd`. Such a read still produces a response, and its `m_rdata` is zero.
- R6: With `BCAST=1`, a write with index 0 raises `s_wr` on all ports at once, with the same offset and data.
- R7: With `BCAST=1`, a read with index 0 is served by port 0 alone. Reads with any other index return zero, and writes with any other index raise no `s_wr`.
- R8: `m_rvalid` is high in exactly the cycles that follow a cycle with `m_rd` high. It is low during reset and in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | ADR_W+SEL_W | Master word address (port index above offset) |
| m_wdata | input | DAT_W | Master write data |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe |
| m_rdata | output | DAT_W | Read data returned to master |
| m_rvalid | output | 1 | Read data valid, one cycle after `m_rd` |
| s_addr | output | N_PORTS*ADR_W | Per-port word offset |
| s_wdata | output | N_PORTS*DAT_W | Per-port write data |
| s_wr | output | N_PORTS | Per-port write strobe |
| s_rd | output | N_PORTS | Per-port read strobe |
| s_rdata | input | N_PORTS*DAT_W | Per-port read data, valid one cycle after `s_rd` |

## Verification
The slave-side strobes, offsets and write data are combinational, so they are due in the same cycle as the master request. The bench checks them a short delay after driving at the falling edge. The read response crosses one slave register and the tracker register, so it is due one clock later. The bench checks `m_rvalid` and `m_rdata` at the next falling edge. Back-to-back sequences check each response while the following read is being driven. Two instances, one per mode, see identical stimulus. Each is compared against its own reference model of the slave register banks.

// File: rtl/mps_pkg.sv
package mps_pkg;

    typedef enum logic [0:0] {
        RT_IDLE = 1'b0,
        RT_RESP = 1'b1
    } rt_state_t;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mps_decode.sv
module mps_decode
    import mps_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADR_W   = 2,
    parameter int SEL_W   = 2,
    parameter bit BCAST   = 1'b0
) (
    input  logic [ADR_W+SEL_W-1:0] addr,
    output logic [SEL_W-1:0]       sel,
    output logic [ADR_W-1:0]       offset,
    output logic                   in_range,
    output logic                   rd_hit
);

    localparam logic [SEL_W:0] NP = (SEL_W+1)'(N_PORTS);

    always_comb begin
        sel      = addr[ADR_W +: SEL_W];
        offset   = addr[ADR_W-1:0];
        in_range = ({1'b0, sel} < NP);
    end

    generate
        if (BCAST) begin : g_bc_hit
            always_comb rd_hit = (sel == '0);
        end else begin : g_ind_hit
            always_comb rd_hit = in_range;
        end
    endgenerate

endmodule

// File: rtl/mps_fanout.sv
module mps_fanout
    import mps_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADR_W   = 2,
    parameter int DAT_W   = 32,
    parameter int SEL_W   = 2,
    parameter bit BCAST   = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEL_W-1:0]         sel,
    input  logic [ADR_W-1:0]         offset,
    input  logic [DAT_W-1:0]         wdata,
    input  logic                     wr,
    input  logic                     rd,
    output logic [N_PORTS*ADR_W-1:0] s_addr,
    output logic [N_PORTS*DAT_W-1:0] s_wdata,
    output logic [N_PORTS-1:0]       s_wr,
    output logic [N_PORTS-1:0]       s_rd
);

    generate
        for (genvar g = 0; g < N_PORTS; g++) begin : g_port
            localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
            always_comb begin
                s_addr[g*ADR_W +: ADR_W]  = offset;
                s_wdata[g*DAT_W +: DAT_W] = wdata;
            end
            if (BCAST) begin : g_bc
                always_comb begin
                    s_wr[g] = wr && (sel == '0);
                    s_rd[g] = rd && (sel == '0) && (g == 0);
                end
            end else begin : g_ind
                always_comb begin
                    s_wr[g] = wr && (sel == IDX);
                    s_rd[g] = rd && (sel == IDX);
                end
            end
        end
    endgenerate

    generate
        if (!BCAST) begin : g_chk_ind
            AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
                $onehot0(s_wr)); // R2
        end else begin : g_chk_bc
            AST_BC_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
                (s_wr == '0) || (&s_wr)); // R6
        end
    endgenerate

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_rd)); // R3

endmodule

// File: rtl/mps_rd_track.sv
module mps_rd_track
    import mps_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  logic [SEL_W-1:0] sel,
    input  logic             hit,
    output logic             rvalid,
    output logic [SEL_W-1:0] sel_q,
    output logic             hit_q
);

    rt_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RT_IDLE;
            sel_q <= '0;
            hit_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (rd) begin
                sel_q <= sel;
                hit_q <= hit;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RT_IDLE: state_nxt = rd ? RT_RESP : RT_IDLE;
            RT_RESP: state_nxt = rd ? RT_RESP : RT_IDLE;
            default: state_nxt = RT_IDLE;
        endcase
    end

    always_comb begin
        rvalid = (state == RT_RESP);
    end

    AST_RV_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid); // R8
    AST_RV_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rvalid); // R8

endmodule

// File: rtl/mps_rd_mux.sv
module mps_rd_mux
    import mps_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int DAT_W   = 32,
    parameter int SEL_W   = 2
) (
    input  logic [N_PORTS*DAT_W-1:0] s_rdata,
    input  logic [SEL_W-1:0]         sel_q,
    input  logic                     hit_q,
    input  logic                     rvalid,
    output logic [DAT_W-1:0]         rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (rvalid && hit_q && (sel_q == SEL_W'(i))) begin
                rdata = s_rdata[i*DAT_W +: DAT_W];
            end
        end
    end

endmodule

// File: rtl/mm_port_split.sv
module mm_port_split
    import mps_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADR_W   = 2,
    parameter int DAT_W   = 32,
    parameter bit BCAST   = 1'b0
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [ADR_W+sel_width(N_PORTS)-1:0]   m_addr,
    input  logic [DAT_W-1:0]                      m_wdata,
    input  logic                                  m_wr,
    input  logic                                  m_rd,
    output logic [DAT_W-1:0]                      m_rdata,
    output logic                                  m_rvalid,
    output logic [N_PORTS*ADR_W-1:0]              s_addr,
    output logic [N_PORTS*DAT_W-1:0]              s_wdata,
    output logic [N_PORTS-1:0]                    s_wr,
    output logic [N_PORTS-1:0]                    s_rd,
    input  logic [N_PORTS*DAT_W-1:0]              s_rdata
);

    localparam int SEL_W = sel_width(N_PORTS);

    logic [SEL_W-1:0] sel;
    logic [ADR_W-1:0] offset;
    logic             in_range;
    logic             rd_hit;
    logic [SEL_W-1:0] sel_q;
    logic             hit_q;

    mps_decode #(
        .N_PORTS(N_PORTS), .ADR_W(ADR_W), .SEL_W(SEL_W), .BCAST(BCAST)
    ) u_decode (
        .addr(m_addr), .sel(sel), .offset(offset),
        .in_range(in_range), .rd_hit(rd_hit)
    );

    mps_fanout #(
        .N_PORTS(N_PORTS), .ADR_W(ADR_W), .DAT_W(DAT_W),
        .SEL_W(SEL_W), .BCAST(BCAST)
    ) u_fanout (
        .clk(clk), .rst(rst), .sel(sel), .offset(offset), .wdata(m_wdata),
        .wr(m_wr), .rd(m_rd), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_wr(s_wr), .s_rd(s_rd)
    );

    mps_rd_track #(
        .SEL_W(SEL_W)
    ) u_track (
        .clk(clk), .rst(rst), .rd(m_rd), .sel(sel), .hit(rd_hit),
        .rvalid(m_rvalid), .sel_q(sel_q), .hit_q(hit_q)
    );

    mps_rd_mux #(
        .N_PORTS(N_PORTS), .DAT_W(DAT_W), .SEL_W(SEL_W)
    ) u_rdmux (
        .s_rdata(s_rdata), .sel_q(sel_q), .hit_q(hit_q),
        .rvalid(m_rvalid), .rdata(m_rdata)
    );

    AST_OOR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> (s_wr == '0) && (s_rd == '0)); // R5
    AST_OOR_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (m_rd && !in_range) |=> (m_rdata == '0)); // R5
    AST_OFFSET_P0: assert property (@(posedge clk) disable iff (rst)
        s_addr[ADR_W-1:0] == m_addr[ADR_W-1:0]); // R1

    generate
        if (BCAST) begin : g_bc_chk
            AST_BC_FANOUT: assert property (@(posedge clk) disable iff (rst)
                (m_wr && (sel == '0)) |-> (&s_wr)); // R6
            AST_BC_NO_OTHER_RD: assert property (@(posedge clk) disable iff (rst)
                (m_rd && (sel != '0)) |=> (m_rdata == '0)); // R7
        end
    endgenerate

endmodule

// File: tb/tb_mm_port_split.sv
`timescale 1ns/100ps

module tb_regbank #(
    parameter int N  = 3,
    parameter int AW = 2,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N*AW-1:0] s_addr,
    input  logic [N*DW-1:0] s_wdata,
    input  logic [N-1:0]    s_wr,
    input  logic [N-1:0]    s_rd,
    output logic [N*DW-1:0] s_rdata
);
    logic [DW-1:0] mem [N][2**AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < N; p++) begin
                for (int w = 0; w < 2**AW; w++) mem[p][w] <= '0;
            end
            s_rdata <= '0;
        end else begin
            for (int p = 0; p < N; p++) begin
                if (s_wr[p]) mem[p][s_addr[p*AW +: AW]] <= s_wdata[p*DW +: DW];
                if (s_rd[p]) s_rdata[p*DW +: DW] <= mem[p][s_addr[p*AW +: AW]];
            end
        end
    end
endmodule

module tb_mm_port_split;
    localparam int N  = 3;
    localparam int AW = 2;
    localparam int DW = 32;
    localparam int SW = 2;
    localparam int MW = AW + SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [MW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic          m_wr = 1'b0;
    logic          m_rd = 1'b0;

    logic [DW-1:0]   rdata_a, rdata_b;
    logic            rv_a, rv_b;
    logic [N*AW-1:0] sa_a, sa_b;
    logic [N*DW-1:0] sw_a, sw_b, sr_a, sr_b;
    logic [N-1:0]    wr_a, wr_b, rd_a, rd_b;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] ea [N][2**AW];
    logic [DW-1:0] eb [N][2**AW];

    always #2.5 clk = ~clk;

    mm_port_split #(.N_PORTS(N), .ADR_W(AW), .DAT_W(DW), .BCAST(1'b0)) dut (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_wr(m_wr),
        .m_rd(m_rd), .m_rdata(rdata_a), .m_rvalid(rv_a), .s_addr(sa_a),
        .s_wdata(sw_a), .s_wr(wr_a), .s_rd(rd_a), .s_rdata(sr_a));
    tb_regbank #(.N(N), .AW(AW), .DW(DW)) u_bank_a (
        .clk(clk), .rst(rst), .s_addr(sa_a), .s_wdata(sw_a), .s_wr(wr_a),
        .s_rd(rd_a), .s_rdata(sr_a));

    mm_port_split #(.N_PORTS(N), .ADR_W(AW), .DAT_W(DW), .BCAST(1'b1)) dut_bc (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_wr(m_wr),
        .m_rd(m_rd), .m_rdata(rdata_b), .m_rvalid(rv_b), .s_addr(sa_b),
        .s_wdata(sw_b), .s_wr(wr_b), .s_rd(rd_b), .s_rdata(sr_b));
    tb_regbank #(.N(N), .AW(AW), .DW(DW)) u_bank_b (
        .clk(clk), .rst(rst), .s_addr(sa_b), .s_wdata(sw_b), .s_wr(wr_b),
        .s_rd(rd_b), .s_rdata(sr_b));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] mask_ind(input logic [MW-1:0] a);
        logic [N-1:0] m = '0;
        for (int p = 0; p < N; p++) if (int'(a[MW-1:AW]) == p) m[p] = 1'b1;
        return m;
    endfunction

    function automatic logic [N-1:0] mask_bc_wr(input logic [MW-1:0] a);
        return (a[MW-1:AW] == '0) ? {N{1'b1}} : '0;
    endfunction

    function automatic logic [N-1:0] mask_bc_rd(input logic [MW-1:0] a);
        return (a[MW-1:AW] == '0) ? N'(1) : '0;
    endfunction

    function automatic logic [DW-1:0] exp_rd_a(input logic [MW-1:0] a);
        int s = int'(a[MW-1:AW]);
        return (s < N) ? ea[s][a[AW-1:0]] : '0;
    endfunction

    function automatic logic [DW-1:0] exp_rd_b(input logic [MW-1:0] a);
        return (a[MW-1:AW] == '0) ? eb[0][a[AW-1:0]] : '0;
    endfunction

    task automatic do_write(input logic [MW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        m_addr = a; m_wdata = d; m_wr = 1'b1; m_rd = 1'b0;
        #1;
        check("R2/R5 wr mask", DW'(wr_a), DW'(mask_ind(a)));
        check("R6/R7 bc wr mask", DW'(wr_b), DW'(mask_bc_wr(a)));
        check("R1 offset", DW'(sa_a[(N-1)*AW +: AW]), DW'(a[AW-1:0]));
        check("R1 wdata", sw_b[(N-1)*DW +: DW], d);
        for (int p = 0; p < N; p++) begin
            if (mask_ind(a)[p]) ea[p][a[AW-1:0]] = d;
            if (mask_bc_wr(a)[p]) eb[p][a[AW-1:0]] = d;
        end
        @(negedge clk);
        m_wr = 1'b0;
        check("R8 rvalid low after write", DW'(rv_a), 0);
    endtask

    task automatic do_read(input logic [MW-1:0] a);
        logic [DW-1:0] xa, xb;
        xa = exp_rd_a(a);
        xb = exp_rd_b(a);
        @(negedge clk);
        m_addr = a; m_rd = 1'b1; m_wr = 1'b0;
        #1;
        check("R3/R5 rd mask", DW'(rd_a), DW'(mask_ind(a)));
        check("R7 bc rd mask", DW'(rd_b), DW'(mask_bc_rd(a)));
        @(negedge clk);
        m_rd = 1'b0;
        check("R8 rvalid", DW'(rv_a), 1);
        check("R8 bc rvalid", DW'(rv_b), 1);
        check("R3/R5 rdata", rdata_a, xa);
        check("R7 bc rdata", rdata_b, xb);
    endtask

    task automatic read_burst(input logic [MW-1:0] a0, input logic [MW-1:0] a1,
                              input logic [MW-1:0] a2);
        logic [MW-1:0] seq [3];
        seq[0] = a0; seq[1] = a1; seq[2] = a2;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k > 0) begin
                check("R4 b2b rvalid", DW'(rv_a), 1);
                check("R4 b2b rdata", rdata_a, exp_rd_a(seq[k-1]));
                check("R4 b2b bc rdata", rdata_b, exp_rd_b(seq[k-1]));
            end
            if (k < 3) begin
                m_addr = seq[k]; m_rd = 1'b1;
            end else begin
                m_rd = 1'b0;
            end
        end
        @(negedge clk);
        check("R8 rvalid drops", DW'(rv_a), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < N; p++) begin
            for (int w = 0; w < 2**AW; w++) begin
                ea[p][w] = '0;
                eb[p][w] = '0;
            end
        end
        void'($urandom(32'd4711));
        m_rd = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset rvalid", DW'(rv_a), 0);
        check("R8 reset bc rvalid", DW'(rv_b), 0);
        m_rd = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R8 first cycle rvalid", DW'(rv_a), 0);

        // directed: one word per port window, then readback
        do_write(4'h1, 32'h1111_0001);
        do_write(4'h6, 32'h2222_0002);
        do_write(4'hB, 32'h3333_0003);
        do_read(4'h1);
        do_read(4'h6);
        do_read(4'hB);
        // broadcast write through window 0 reaches every port of dut_bc
        do_write(4'h2, 32'hA5A5_5A5A);
        for (int p = 0; p < N; p++) check("R6 bc model fanout", eb[p][2], 32'hA5A5_5A5A);
        // out-of-range window 3
        do_write(4'hD, 32'hDEAD_BEEF);
        do_read(4'hD);
        do_read(4'hF);
        // non-zero window in broadcast instance
        do_read(4'h6);
        // back-to-back reads across ports
        read_burst(4'h1, 4'h6, 4'hB);
        read_burst(4'hB, 4'h2, 4'hD);

        for (int i = 0; i < 400; i++) begin
            logic [MW-1:0] a;
            a = MW'($urandom % (1 << MW));
            if ($urandom % 2 == 0) do_write(a, $urandom);
            else do_read(a);
        end
        for (int i = 0; i < 20; i++) begin
            read_burst(MW'($urandom), MW'($urandom), MW'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule